// File: doc/BRIEF.md
# Two-Road Priority Traffic Light Controller

This block drives the lamps at a crossing where a busy main road meets a quiet side road. The main road keeps its green for as long as no vehicle waits on the side road. Once a vehicle is reported there and the main road has held green for a minimum time, the main road steps through yellow to red and the side road gets green. The side road keeps green only while vehicles are still reported, up to a fixed maximum. After that it steps through yellow, and right-of-way returns to the main road.

Time is counted in ticks. A tick is a one-cycle pulse on `sec_tick`, normally once per second, and it runs alongside the system clock. One shared interval counter measures how long the current phase has lasted, and the controller restarts it whenever the phase changes. The vehicle-detect input is asynchronous to the clock, so it passes through a two-stage synchronizer before it is used.

Top module: `tlc_junction`

## Requirements
- R1: While `rst` is high, and right after its release, the lamps show main green with side red, and the interval count is zero.
- R2: In every cycle exactly one of the three lamps of each road is lit. The two roads never show green or yellow at the same time.
- R3: While main green is shown and no side vehicle is reported, main green stays on, however many ticks pass.
- R4: Main green changes to main yellow only when at least 30 ticks have passed in main green and a side vehicle is reported. The change appears on the clock edge after the 30th tick is counted.
- R5: Side green changes to side yellow on the edge after the 16th tick in side green, or when the reported vehicle signal is low, whichever comes first.
- R6: The phases always run in the order main green, main yellow, side green, side yellow, main green. Each yellow shows for exactly 3 ticks and then gives green to the other road on the following edge.
- R7: A change on `side_car` takes effect on the controller three clock edges after it is applied: two edges for the synchronizer and one for the phase register.
- R8: The interval count restarts at zero whenever the phase changes. A tick in the cycle of a phase change is not counted. Time spent in one phase, such as a long main green or a full side green, never shortens the next phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle timing pulse, normally once per second |
| side_car | input | 1 | Vehicle present on the side road (asynchronous) |
| main_red | output | 1 | Main road red lamp |
| main_yellow | output | 1 | Main road yellow lamp |
| main_green | output | 1 | Main road green lamp |
| side_red | output | 1 | Side road red lamp |
| side_yellow | output | 1 | Side road yellow lamp |
| side_green | output | 1 | Side road green lamp |

## Verification
The key collision is a tick that arrives in the same cycle as a phase change. The restart must win, so the new phase starts at zero and not at one. A second case is side green where the 16th tick and a vehicle drop arrive together.

The random phase drives a tick on about a third of the cycles and switches the vehicle signal rarely. This makes both collisions happen many times. A cycle-level model in the bench is built from the requirements, and the lamps are compared against it on every cycle.

Directed sequences then count exact tick totals at the boundaries 29/30, 15/16 and 2/3. They also count the three-edge lag from the detect input.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Gray-ordered phase codes: each legal step flips one bit
    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'b00,
        PH_MAIN_WARN = 2'b01,
        PH_SIDE_GO   = 2'b11,
        PH_SIDE_WARN = 2'b10
    } phase_e;

    typedef struct packed {
        logic main_red;
        logic main_yel;
        logic main_grn;
        logic side_red;
        logic side_yel;
        logic side_grn;
    } lamps_t;

    function automatic lamps_t phase_lamps(input phase_e ph);
        lamps_t l;
        l = '0;
        case (ph)
            PH_MAIN_GO:   begin l.main_grn = 1'b1; l.side_red = 1'b1; end
            PH_MAIN_WARN: begin l.main_yel = 1'b1; l.side_red = 1'b1; end
            PH_SIDE_GO:   begin l.main_red = 1'b1; l.side_grn = 1'b1; end
            default:      begin l.main_red = 1'b1; l.side_yel = 1'b1; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st;

    sync_st st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb st_d.chain = din;
        end else begin : g_multi
            always_comb st_d.chain = {st_q.chain[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/tlc_timer.sv
module tlc_timer #(
    parameter int MAIN_MIN = 30,
    parameter int SIDE_MAX = 16,
    parameter int WARN_LEN = 3,
    parameter int CNT_MAX  = 30,
    parameter int CNT_W    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic main_min_done,
    output logic side_max_done,
    output logic warn_done
);

    localparam logic [CNT_W-1:0] LIM_MAIN = CNT_W'(MAIN_MIN);
    localparam logic [CNT_W-1:0] LIM_SIDE = CNT_W'(SIDE_MAX);
    localparam logic [CNT_W-1:0] LIM_WARN = CNT_W'(WARN_LEN);
    localparam logic [CNT_W-1:0] LIM_SAT  = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st;

    tmr_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart)
            st_d.cnt = '0;
        else if (tick && (st_q.cnt != LIM_SAT))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign main_min_done = (st_q.cnt >= LIM_MAIN);
    assign side_max_done = (st_q.cnt >= LIM_SIDE);
    assign warn_done     = (st_q.cnt >= LIM_WARN);

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (st_q.cnt == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LIM_SAT);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(st_q.cnt));

endmodule

// File: rtl/tlc_fsm.sv
module tlc_fsm
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car,
    input  logic   main_min_done,
    input  logic   side_max_done,
    input  logic   warn_done,
    output phase_e phase,
    output logic   restart
);

    typedef struct packed {
        phase_e ph;
    } fsm_st;

    fsm_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_MAIN_GO:   if (main_min_done && car)  st_d.ph = PH_MAIN_WARN;
            PH_MAIN_WARN: if (warn_done)             st_d.ph = PH_SIDE_GO;
            PH_SIDE_GO:   if (side_max_done || !car) st_d.ph = PH_SIDE_WARN;
            PH_SIDE_WARN: if (warn_done)             st_d.ph = PH_MAIN_GO;
            default:                                 st_d.ph = PH_MAIN_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.ph <= PH_MAIN_GO;
        else     st_q    <= st_d;
    end

    assign phase   = st_q.ph;
    assign restart = (st_d.ph != st_q.ph);

    // R6
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != $past(st_q.ph)) |-> ($countones(st_q.ph ^ $past(st_q.ph)) == 1));

    // R6
    order_main_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_MAIN_GO) |=> (st_q.ph == PH_MAIN_GO || st_q.ph == PH_MAIN_WARN));

    // R6
    order_side_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_SIDE_GO) |=> (st_q.ph == PH_SIDE_GO || st_q.ph == PH_SIDE_WARN));

    // R3
    main_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_MAIN_GO && !car) |=> (st_q.ph == PH_MAIN_GO));

    // R4
    main_early_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_MAIN_GO && !main_min_done) |=> (st_q.ph == PH_MAIN_GO));

    // R5
    side_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_SIDE_GO && !car) |=> (st_q.ph == PH_SIDE_WARN));

endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
    import tlc_pkg::*;
#(
    parameter int MAIN_MIN    = 30,
    parameter int SIDE_MAX    = 16,
    parameter int WARN_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic side_car,
    output logic main_red,
    output logic main_yellow,
    output logic main_green,
    output logic side_red,
    output logic side_yellow,
    output logic side_green
);

    localparam int MAX_AB  = (MAIN_MIN > SIDE_MAX) ? MAIN_MIN : SIDE_MAX;
    localparam int CNT_MAX = (MAX_AB > WARN_LEN) ? MAX_AB : WARN_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic   car_s;
    logic   restart;
    logic   min_done, max_done, warn_done;
    phase_e phase;
    lamps_t lamps;

    tlc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (side_car),
        .dout (car_s)
    );

    tlc_timer #(
        .MAIN_MIN (MAIN_MIN),
        .SIDE_MAX (SIDE_MAX),
        .WARN_LEN (WARN_LEN),
        .CNT_MAX  (CNT_MAX),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .restart       (restart),
        .tick          (sec_tick),
        .main_min_done (min_done),
        .side_max_done (max_done),
        .warn_done     (warn_done)
    );

    tlc_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .car           (car_s),
        .main_min_done (min_done),
        .side_max_done (max_done),
        .warn_done     (warn_done),
        .phase         (phase),
        .restart       (restart)
    );

    always_comb lamps = phase_lamps(phase);

    assign main_red    = lamps.main_red;
    assign main_yellow = lamps.main_yel;
    assign main_green  = lamps.main_grn;
    assign side_red    = lamps.side_red;
    assign side_yellow = lamps.side_yel;
    assign side_green  = lamps.side_grn;

    // R2
    main_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({main_red, main_yellow, main_green}) == 1);

    // R2
    side_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({side_red, side_yellow, side_green}) == 1);

    // R2
    no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        main_red || side_red);

endmodule

// File: tb/tlc_junction_bench.sv
module tlc_junction_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0;
    logic side_car = 1'b0;
    logic main_red, main_yellow, main_green, side_red, side_yellow, side_green;

    int errors = 0;
    int checks = 0;
    int cyc_n  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlc_junction u_tlc_junction (
        .clk         (clk),
        .rst         (rst),
        .sec_tick    (sec_tick),
        .side_car    (side_car),
        .main_red    (main_red),
        .main_yellow (main_yellow),
        .main_green  (main_green),
        .side_red    (side_red),
        .side_yellow (side_yellow),
        .side_green  (side_green)
    );

    // Model phases: 0 main green, 1 main yellow, 2 side green, 3 side yellow
    int m_ph = 0;
    int m_cnt = 0;
    bit m_s1 = 1'b0, m_s2 = 1'b0;

    function automatic int next_ph(int ph, int cnt, bit car);
        case (ph)
            0: return (cnt >= 30 && car) ? 1 : 0;
            1: return (cnt >= 3) ? 2 : 1;
            2: return (cnt >= 16 || !car) ? 3 : 2;
            default: return (cnt >= 3) ? 0 : 3;
        endcase
    endfunction

    function automatic logic [5:0] ph_lamps(int ph);
        case (ph)
            0: return 6'b001_100;
            1: return 6'b010_100;
            2: return 6'b100_001;
            default: return 6'b100_010;
        endcase
    endfunction

    function automatic logic [5:0] seen();
        return {main_red, main_yellow, main_green, side_red, side_yellow, side_green};
    endfunction

    always @(posedge clk) begin
        int np;
        if (rst) begin
            m_ph <= 0; m_cnt <= 0; m_s1 <= 1'b0; m_s2 <= 1'b0;
        end else begin
            np = next_ph(m_ph, m_cnt, m_s2);
            m_s1 <= side_car;
            m_s2 <= m_s1;
            if (np != m_ph)                      m_cnt <= 0;
            else if (sec_tick && m_cnt < 30)     m_cnt <= m_cnt + 1;
            m_ph <= np;
        end
    end

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    // Continuous comparison against the model and the lamp rules
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 R4 R5 R6 R7 R8 model", seen(), ph_lamps(m_ph));
            chk("R2 one lamp per road",
                {4'b0, ($countones({main_red, main_yellow, main_green}) == 1),
                       ($countones({side_red, side_yellow, side_green}) == 1)},
                6'b000011);
            chk("R2 no conflict", {5'b0, (main_red | side_red)}, 6'b000001);
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Starts and ends at a falling edge; outputs then reflect that rising edge
    task automatic step(bit t, bit c);
        sec_tick = t;
        side_car = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [5:0] L_MG = 6'b001_100;
    localparam logic [5:0] L_MY = 6'b010_100;
    localparam logic [5:0] L_SG = 6'b100_001;
    localparam logic [5:0] L_SY = 6'b100_010;

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 during reset", seen(), L_MG);
        rst = 1'b0;
        step(1, 0);
        chk("R1 after release", seen(), L_MG);

        // R3: no side vehicle, many ticks
        for (int i = 0; i < 100; i++) step(1, 0);
        chk("R3 held green", seen(), L_MG);

        // R7: detect lag of three edges
        step(0, 1);
        chk("R7 edge1", seen(), L_MG);
        step(0, 1);
        chk("R7 edge2", seen(), L_MG);
        step(0, 1);
        chk("R7 edge3 R4", seen(), L_MY);

        // R6: main yellow 3 ticks
        step(1, 1); step(1, 1); step(1, 1);
        chk("R6 main yellow after 3 ticks", seen(), L_MY);
        step(0, 1);
        chk("R6 side green", seen(), L_SG);

        // R5 maximum and R8 fresh count after long main green
        for (int i = 0; i < 15; i++) step(1, 1);
        chk("R8 R5 side green at 15", seen(), L_SG);
        step(1, 1);
        chk("R5 side green at 16", seen(), L_SG);
        step(0, 1);
        chk("R5 side yellow at max", seen(), L_SY);

        // R6 R8: yellow after a full side green still lasts 3 ticks
        step(1, 1); step(1, 1);
        chk("R8 side yellow at 2", seen(), L_SY);
        step(1, 1);
        step(0, 1);
        chk("R6 back to main green", seen(), L_MG);

        // R4 minimum boundary with vehicle present
        for (int i = 0; i < 29; i++) step(1, 1);
        step(0, 1);
        chk("R4 main green at 29", seen(), L_MG);
        step(1, 1);
        chk("R4 main green at 30", seen(), L_MG);
        step(0, 1);
        chk("R4 main yellow after 30", seen(), L_MY);

        // R5 early end when vehicle clears
        step(1, 1); step(1, 1); step(1, 1); step(0, 1);
        chk("R6 side green again", seen(), L_SG);
        step(1, 1); step(1, 1);
        step(0, 0);
        chk("R5 clear edge1", seen(), L_SG);
        step(0, 0);
        chk("R5 clear edge2", seen(), L_SG);
        step(0, 0);
        chk("R5 early side yellow", seen(), L_SY);

        // Random traffic; ticks collide with phase changes
        begin
            bit car = 1'b0;
            for (int i = 0; i < 30000; i++) begin
                if ($urandom_range(0, 39) == 0) car = ~car;
                step(($urandom_range(0, 2) == 0), car);
            end
        end

        // R1: reset in the middle of traffic
        side_car = 1'b1;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid-run reset", seen(), L_MG);
        rst = 1'b0;
        step(0, 1); step(0, 1); step(0, 1);
        chk("R1 R8 count zero after reset", seen(), L_MG);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule